// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

This block gathers 32 level-sensitive interrupt lines for a primary interrupt controller. It records the current level of every line in a raw level register and applies a software-programmed enable mask. Whenever any enabled line is pending, it raises one combined request on output bit 31. Priority and vectoring are left to the primary controller.

A second register, the direct-route enable, lets lines 21 to 30 bypass the mask. Each such line is then forwarded to its own output bit, so the primary controller can see it as a separate source. Software reaches the registers over a plain strobe bus inside a 4 KB window. The register index is the byte address divided by four.

The bus is control-only and has no back-pressure. A write takes effect on the clock edge where `bus_wr` is sampled high. A read returns its data on the cycle after the edge where `bus_rd` is sampled high. There is no valid/ready handshake, because the block can always accept an access.

Top module: `irq_fanin_ctrl`

## Requirements
- R1: Each bit of the raw level register takes the value of its `irq_in` line on every clock edge. Register index 1 reads the raw level register back.
- R2: A read returns data on `bus_rdata` one cycle after `bus_rd` is sampled. Index 0 returns raw level AND enable mask, index 1 returns raw level, and index 2 returns the enable mask. The index is `bus_addr[11:2]`.
- R3: A write to index 2 ORs `bus_wdata` into the enable mask. A write to index 3 clears every enable bit that is set in `bus_wdata`.
- R4: Index 4 reads raw level bit 0 in bit 0, with every other bit zero. A write of any nonzero value to index 4 sets enable bit 0, and a nonzero write to index 5 clears it. A zero write to either index has no effect, and no other enable bit is touched.
- R5: Index 8 reads the direct-route enable. A write to index 8 ORs in `bus_wdata & 32'h7FE0_0000`, so only bits 21 to 30 can ever be set. A write to index 9 clears every route bit that is set in `bus_wdata`.
- R6: `irq_out[31]` is high exactly when (raw level AND enable mask) was nonzero one cycle earlier.
- R7: For each i in 21 to 30, `irq_out[i]` equals (route bit i AND raw level bit i) from one cycle earlier, whatever the enable mask holds.
- R8: `irq_out[20:0]` is always low, and an output in 21 to 30 whose route bit is clear is low.
- R9: Reads of indices 3, 5, 6, 7 and 10 to 1023 return zero. Writes to indices 0, 1, 6, 7 and 10 to 1023 change no register.
- R10: Reset (`rst_n` low) clears the raw level, enable mask and route registers, and every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level-sensitive interrupt lines |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| irq_out | output | 32 | Routed lines 21 to 30 and combined request on bit 31 |

## Verification
Results arrive at different delays:
- A change on `irq_in` is visible to register reads after one clock edge and on `irq_out` after two.
- A register write is visible to reads after one edge and on `irq_out` after two.
- Read data is captured on the edge that samples the request.

The bench drives every input on a falling edge and counts the rising edges each result needs before sampling on the next falling edge. It also checks `irq_out` once more, one edge too early, to confirm that the outputs change on exactly the cycle they are due.

// File: rtl/irq_fanin_pkg.sv
package irq_fanin_pkg;
  // Register indices (byte offset >> 2); software depends on these values.
  localparam int unsigned IDX_PEND     = 0;
  localparam int unsigned IDX_RAW      = 1;
  localparam int unsigned IDX_EN_SET   = 2;
  localparam int unsigned IDX_EN_CLR   = 3;
  localparam int unsigned IDX_SOFT_SET = 4;
  localparam int unsigned IDX_SOFT_CLR = 5;
  localparam int unsigned IDX_RT_SET   = 8;
  localparam int unsigned IDX_RT_CLR   = 9;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_EN_OR,
    OP_EN_ANDN,
    OP_SOFT_ON,
    OP_SOFT_OFF,
    OP_RT_OR,
    OP_RT_ANDN
  } wr_op_e;
endpackage

// File: rtl/irq_level_track.sv
module irq_level_track #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic [NUM_SRC-1:0] lvl_q
);
  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) lvl_q[g] <= 1'b0;
        else        lvl_q[g] <= irq_in[g];
      end
    end
  endgenerate
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_fanin_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned RT_LO    = 21,
  parameter int unsigned RT_HI    = 30,
  parameter int unsigned SOFT_BIT = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  input  logic               bus_rd,
  input  logic [NUM_SRC-1:0] lvl_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] rt_q,
  output logic [NUM_SRC-1:0] bus_rdata
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   idx;
  logic [NUM_SRC-1:0] rt_allow;
  logic [NUM_SRC-1:0] soft_sel;
  wr_op_e             op;
  logic [NUM_SRC-1:0] mask_d, rt_d, rd_d;
  logic               wdata_nz;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign wdata_nz = |bus_wdata;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_allow
      assign rt_allow[g] = (g >= RT_LO) && (g <= RT_HI);
      assign soft_sel[g] = (g == SOFT_BIT);
    end
  endgenerate

  // Write decode
  always_comb begin
    op = OP_NONE;
    if (bus_wr) begin
      if      (idx == IDX_W'(IDX_EN_SET))               op = OP_EN_OR;
      else if (idx == IDX_W'(IDX_EN_CLR))               op = OP_EN_ANDN;
      else if (idx == IDX_W'(IDX_SOFT_SET) && wdata_nz) op = OP_SOFT_ON;
      else if (idx == IDX_W'(IDX_SOFT_CLR) && wdata_nz) op = OP_SOFT_OFF;
      else if (idx == IDX_W'(IDX_RT_SET))               op = OP_RT_OR;
      else if (idx == IDX_W'(IDX_RT_CLR))               op = OP_RT_ANDN;
    end
  end

  always_comb begin
    mask_d = mask_q;
    rt_d   = rt_q;
    unique case (op)
      OP_EN_OR:    mask_d = mask_q | bus_wdata;
      OP_EN_ANDN:  mask_d = mask_q & ~bus_wdata;
      OP_SOFT_ON:  mask_d = mask_q | soft_sel;
      OP_SOFT_OFF: mask_d = mask_q & ~soft_sel;
      OP_RT_OR:    rt_d   = rt_q | (bus_wdata & rt_allow);
      OP_RT_ANDN:  rt_d   = rt_q & ~bus_wdata;
      default: ;
    endcase
  end

  // Read mux
  always_comb begin
    rd_d = '0;
    if      (idx == IDX_W'(IDX_PEND))     rd_d = lvl_q & mask_q;
    else if (idx == IDX_W'(IDX_RAW))      rd_d = lvl_q;
    else if (idx == IDX_W'(IDX_EN_SET))   rd_d = mask_q;
    else if (idx == IDX_W'(IDX_SOFT_SET)) rd_d = lvl_q & soft_sel;
    else if (idx == IDX_W'(IDX_RT_SET))   rd_d = rt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      rt_q      <= '0;
      bus_rdata <= '0;
    end else begin
      mask_q <= mask_d;
      rt_q   <= rt_d;
      if (bus_rd) bus_rdata <= rd_d;
    end
  end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned RT_LO    = 21,
  parameter int unsigned RT_HI    = 30,
  parameter int unsigned COMB_BIT = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] lvl_q,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0] rt_q,
  output logic [NUM_SRC-1:0] irq_out
);
  logic [NUM_SRC-1:0] out_d;
  logic               any_pend;

  assign any_pend = |(lvl_q & mask_q);

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_out
      if (g == COMB_BIT) begin : g_comb
        assign out_d[g] = any_pend;
      end else if (g >= RT_LO && g <= RT_HI) begin : g_direct
        assign out_d[g] = rt_q[g] & lvl_q[g];
      end else begin : g_tie
        assign out_d[g] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= out_d;
  end
endmodule

// File: rtl/irq_fanin_ctrl.sv
module irq_fanin_ctrl #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned RT_LO    = 21,
  parameter int unsigned RT_HI    = 30,
  parameter int unsigned COMB_BIT = NUM_SRC - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  input  logic               bus_rd,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic [NUM_SRC-1:0] irq_out
);
  logic [NUM_SRC-1:0] lvl_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] rt_q;

  irq_level_track #(.NUM_SRC(NUM_SRC)) u_lvl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl_q(lvl_q)
  );

  irq_regfile #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .RT_LO(RT_LO), .RT_HI(RT_HI), .SOFT_BIT(0)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .lvl_q(lvl_q),
    .mask_q(mask_q), .rt_q(rt_q), .bus_rdata(bus_rdata)
  );

  irq_route #(
    .NUM_SRC(NUM_SRC), .RT_LO(RT_LO), .RT_HI(RT_HI), .COMB_BIT(COMB_BIT)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .lvl_q(lvl_q), .mask_q(mask_q),
    .rt_q(rt_q), .irq_out(irq_out)
  );
endmodule

// File: rtl/irq_fanin_chk.sv
module irq_fanin_chk #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned RT_LO    = 21,
  parameter int unsigned RT_HI    = 30,
  parameter int unsigned COMB_BIT = NUM_SRC - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_in,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [NUM_SRC-1:0] bus_wdata,
  input logic               bus_rd,
  input logic [NUM_SRC-1:0] bus_rdata,
  input logic [NUM_SRC-1:0] irq_out,
  input logic [NUM_SRC-1:0] lvl_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] rt_q
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n) warm_q <= 1'b0;
    else        warm_q <= 1'b1;
  end

  logic [IDX_W-1:0] idx;
  logic             rd_known;
  assign idx      = bus_addr[ADDR_W-1:2];
  assign rd_known = (idx == IDX_W'(0)) || (idx == IDX_W'(1)) || (idx == IDX_W'(2)) ||
                    (idx == IDX_W'(4)) || (idx == IDX_W'(8));

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
    lvl_q == $past(irq_in)); // R1

  AST_EN_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx == IDX_W'(2)) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R3

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx == IDX_W'(3)) |=> ((mask_q & $past(bus_wdata)) == '0)); // R3

  AST_RT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_q[RT_LO-1:0] == '0) && (rt_q[NUM_SRC-1:RT_HI+1] == '0)); // R5

  AST_COMB_REQ: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
    irq_out[COMB_BIT] == (|$past(lvl_q & mask_q))); // R6

  AST_DIRECT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
    irq_out[RT_HI:RT_LO] == $past(lvl_q[RT_HI:RT_LO] & rt_q[RT_HI:RT_LO])); // R7

  AST_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[RT_LO-1:0] == '0); // R8

  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_known) |=> (bus_rdata == '0)); // R9
endmodule

bind irq_fanin_ctrl irq_fanin_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .RT_LO(RT_LO), .RT_HI(RT_HI), .COMB_BIT(COMB_BIT)
) u_chk (.*);

// File: tb/irq_fanin_ctrl_test.sv
module irq_fanin_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk; // 200 MHz

  irq_fanin_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Inputs change at a falling edge; state register at next rise, outputs one rise later.
  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    bus_addr = 12'(idx << 2); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    bus_addr = 12'(idx << 2); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
    logic [31:0] d;
    rd(idx, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    irq_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R10 outputs low in reset", irq_out, 32'h0);
    irq_in = '0;
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R10 raw cleared", 1, 32'h0);
    rd_chk("R10 mask cleared", 2, 32'h0);
    rd_chk("R10 route cleared", 8, 32'h0);
    check("R10 outputs low after reset", irq_out, 32'h0);
  endtask

  task automatic t_level();
    irq_in = 32'hA5A5_0F0F;
    @(negedge clk);
    rd_chk("R1 raw level one edge later", 1, 32'hA5A5_0F0F);
    rd_chk("R2 pending with zero mask", 0, 32'h0);
    irq_in = 32'h0000_0F0F;
    @(negedge clk);
    rd_chk("R1 raw level follows fall", 1, 32'h0000_0F0F);
  endtask

  task automatic t_mask();
    wr(2, 32'h0000_0F00);
    rd_chk("R3 set mask", 2, 32'h0000_0F00);
    wr(2, 32'h0000_00F0);
    rd_chk("R3 set ORs", 2, 32'h0000_0FF0);
    rd_chk("R2 pending read", 0, 32'h0000_0F00);
    @(posedge clk); @(negedge clk);
    check("R6 combined high", irq_out, 32'h8000_0000);
    wr(3, 32'h0000_0F00);
    check("R6 combined not early", irq_out, 32'h8000_0000);
    @(posedge clk); @(negedge clk);
    check("R6 combined low after clear", irq_out, 32'h0);
    rd_chk("R3 clear mask bits", 2, 32'h0000_00F0);
  endtask

  task automatic t_soft();
    irq_in = 32'h0000_0003;
    @(negedge clk);
    rd_chk("R4 soft read bit0 only", 4, 32'h0000_0001);
    wr(5, 32'h0000_FFFF);
    rd_chk("R4 soft clear leaves others", 2, 32'h0000_00F0);
    wr(4, 32'h0);
    rd_chk("R4 zero write ignored", 2, 32'h0000_00F0);
    wr(4, 32'h0000_0080);
    rd_chk("R4 soft set bit0", 2, 32'h0000_00F1);
    @(posedge clk); @(negedge clk);
    check("R6 combined via soft bit", irq_out, 32'h8000_0000);
    wr(5, 32'h1);
    @(posedge clk); @(negedge clk);
    check("R6 combined drops", irq_out, 32'h0);
    irq_in = 32'h0000_0002;
    @(negedge clk);
    rd_chk("R4 soft read ignores bit1", 4, 32'h0);
  endtask

  task automatic t_route();
    wr(3, 32'hFFFF_FFFF);
    irq_in = 32'hFFFF_FFFF;
    wr(8, 32'hFFFF_FFFF);
    rd_chk("R5 route set limited", 8, 32'h7FE0_0000);
    settle();
    check("R7 R8 direct lines, mask zero", irq_out, 32'h7FE0_0000);
    wr(9, 32'h0060_0000);
    rd_chk("R5 route clear", 8, 32'h7F80_0000);
    check("R8 cleared routes low", irq_out, 32'h7F80_0000);
    irq_in = 32'h2AA0_0000;
    @(posedge clk);
    @(negedge clk);
    check("R7 not yet changed", irq_out, 32'h7F80_0000);
    @(posedge clk); @(negedge clk);
    check("R7 direct follows level", irq_out, 32'h2A80_0000);
  endtask

  task automatic t_undef();
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    wr(10, 32'hFFFF_FFFF);
    wr(1023, 32'hFFFF_FFFF);
    rd_chk("R9 undefined writes leave mask", 2, 32'h0);
    rd_chk("R9 undefined writes leave route", 8, 32'h7F80_0000);
    rd_chk("R9 read idx3 zero", 3, 32'h0);
    rd_chk("R9 read idx5 zero", 5, 32'h0);
    rd_chk("R9 read idx7 zero", 7, 32'h0);
    rd_chk("R9 read idx9 zero", 9, 32'h0);
    rd_chk("R9 read idx1023 zero", 1023, 32'h0);
    check("R9 outputs unchanged", irq_out, 32'h2A80_0000);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_level();
    t_mask();
    t_soft();
    t_route();
    t_undef();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule